// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block keeps a 256-bit device secret as eight 32-bit words and makes it readable through a small word-addressed register port. Every secret word gives up its value exactly once between resets. The first read returns the stored word and marks that word as consumed. From then on any read of that word returns zero. Only a reset clears the consumed marks. The secret value is fixed when the design is built and enters as a parameter.

Three identification words also sit behind the port: two name words and one version word. When the application-mode input is high, the whole store is hidden. Identification words and secret words then read as zero, and such reads leave the consumed marks untouched. The port is read-only, so write strobes have no effect. Each read strobe returns its data one clock later, together with a one-cycle ready pulse.

Word addresses: 0x00 holds the first name word, 0x01 the second name word and 0x02 the version word. Secret word k sits at `SEC_BASE + k`, with a default of 0x10 to 0x17. Every other address reads as zero.

Top module: `ros_secret_store`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rdy_o` is 0 and `rdata_o` is 0.
- R2: A cycle with `cs_i` and `rd_i` both high gives `rdy_o` high in the next cycle. In every other case `rdy_o` is low in the next cycle.
- R3: In firmware mode (`app_mode_i` low), a read of word address 0x00 returns `NAME0`, of 0x01 returns `NAME1` and of 0x02 returns `VERSION`, with the data in the ready cycle.
- R4: In firmware mode, the first read after reset of address `SEC_BASE+k` (k from 0 to 7) returns `SECRET[32*k +: 32]`.
- R5: Every later read of a secret word that has already been returned once gives zero. Secret words that have not been read yet keep their values.
- R6: A consumed secret word stays consumed until reset. After a reset, the first read of that word returns its value again.
- R7: While `app_mode_i` is high, every read returns zero and consumes no secret word. A word read in this mode still returns its value at its first read in firmware mode.
- R8: A cycle with `cs_i` and `wr_i` high but `rd_i` low produces no ready pulse and consumes no secret word.
- R9: A read of an address that maps to no identification or secret word returns zero, with a ready pulse.
- R10: `rdata_o` is zero in every cycle in which `rdy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all consumed marks |
| cs_i | input | 1 | Chip select for this store |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (accepted and ignored) |
| addr_i | input | ADDR_W | Word address |
| app_mode_i | input | 1 | High while the device runs in application mode; hides the store |
| rdata_o | output | DATA_W | Registered read data, zero when no ready |
| rdy_o | output | 1 | One-cycle pulse marking valid read data |

## Verification
All results arrive exactly one cycle after the strobe that causes them. The ready pulse and the read data follow a read strobe by one clock, and a consumed mark set by a read first shows up in the next read of that word. The bench drives each access at a falling edge, samples just after the following rising edge, and then drops the strobe. It then checks the cycle after as well, to confirm that the ready pulse lasts a single cycle and the data has returned to zero. A bench model keeps its own consumed marks, so random mixes of reads, writes, mode changes and resets each get their expected value before the result is sampled.

// File: rtl/ros_pkg.sv
`timescale 1ns/1ps
package ros_pkg;

  // Which region a word address falls into
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ID     = 2'd1,
    SEL_SECRET = 2'd2
  } ros_sel_e;

  // Number of identification words (two names, one version)
  localparam int ID_WORDS = 3;

endpackage

// File: rtl/ros_addr_decode.sv
`timescale 1ns/1ps
module ros_addr_decode
  import ros_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WORDS    = 8,
  parameter int ID_BASE  = 0,
  parameter int SEC_BASE = 16,
  localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output ros_sel_e          sel_o,
  output logic [1:0]        id_idx_o,
  output logic [IDX_W-1:0]  sec_idx_o
);

  localparam logic [ADDR_W:0] ID_BASE_X  = (ADDR_W+1)'(ID_BASE);
  localparam logic [ADDR_W:0] SEC_BASE_X = (ADDR_W+1)'(SEC_BASE);

  logic [ADDR_W:0] id_off;
  logic [ADDR_W:0] sec_off;

  // Offsets into each region; the extra bit makes an address below a base
  // wrap to a large value that fails the range compare.
  assign id_off  = {1'b0, addr_i} - ID_BASE_X;
  assign sec_off = {1'b0, addr_i} - SEC_BASE_X;

  always_comb begin
    sel_o     = SEL_NONE;
    id_idx_o  = id_off[1:0];
    sec_idx_o = sec_off[IDX_W-1:0];
    if (sec_off < (ADDR_W+1)'(WORDS)) begin
      sel_o = SEL_SECRET;
    end else if (id_off < (ADDR_W+1)'(ID_WORDS)) begin
      sel_o = SEL_ID;
    end
  end

endmodule

// File: rtl/ros_fuse_bank.sv
`timescale 1ns/1ps
module ros_fuse_bank #(
  parameter int WORDS  = 8,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burn_i,
  input  logic [IDX_W-1:0] burn_idx_i,
  input  logic             app_mode_i,
  output logic [WORDS-1:0] consumed_o
);

  logic [WORDS-1:0] consumed_q;

  // One sticky mark per secret word, set by its first visible read
  for (genvar i = 0; i < WORDS; i++) begin : g_mark
    always_ff @(posedge clk) begin
      if (rst) begin
        consumed_q[i] <= 1'b0;
      end else if (burn_i && (burn_idx_i == IDX_W'(i))) begin
        consumed_q[i] <= 1'b1;
      end
    end

    AST_MARK_STICKY: assert property (@(posedge clk) disable iff (rst)
      consumed_q[i] |=> consumed_q[i]); // R6
  end

  assign consumed_o = consumed_q;

  AST_ONE_BURN_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(consumed_q & ~$past(consumed_q)) <= 1); // R5

  AST_APP_NO_BURN: assert property (@(posedge clk) disable iff (rst)
    app_mode_i |=> consumed_q == $past(consumed_q)); // R7

endmodule

// File: rtl/ros_read_port.sv
`timescale 1ns/1ps
module ros_read_port
  import ros_pkg::*;
#(
  parameter int                      DATA_W  = 32,
  parameter int                      WORDS   = 8,
  parameter logic [DATA_W-1:0]       NAME0   = 32'h7365_6b72,
  parameter logic [DATA_W-1:0]       NAME1   = 32'h6f6e_6365,
  parameter logic [DATA_W-1:0]       VERSION = 32'h0000_0001,
  parameter logic [DATA_W*WORDS-1:0] SECRET  = '0,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic              app_mode_i,
  input  ros_sel_e          sel_i,
  input  logic [1:0]        id_idx_i,
  input  logic [IDX_W-1:0]  sec_idx_i,
  input  logic [WORDS-1:0]  consumed_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdy_o
);

  logic [DATA_W-1:0] sec_words [WORDS];
  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] sec_word;
  logic [DATA_W-1:0] next_word;
  logic [DATA_W-1:0] rdata_q;
  logic              rdy_q;

  for (genvar k = 0; k < WORDS; k++) begin : g_unpack
    assign sec_words[k] = SECRET[DATA_W*k +: DATA_W];
  end

  always_comb begin
    unique case (id_idx_i)
      2'd0:    id_word = NAME0;
      2'd1:    id_word = NAME1;
      2'd2:    id_word = VERSION;
      default: id_word = '0;
    endcase
  end

  // A consumed word is blanked before it reaches the output register
  assign sec_word = consumed_i[sec_idx_i] ? '0 : sec_words[sec_idx_i];

  always_comb begin
    next_word = '0;
    if (!app_mode_i) begin
      unique case (sel_i)
        SEL_ID:     next_word = id_word;
        SEL_SECRET: next_word = sec_word;
        default:    next_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdata_q <= fire_i ? next_word : '0;
      rdy_q   <= fire_i;
    end
  end

  assign rdata_o = rdata_q;
  assign rdy_o   = rdy_q;

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rdy_q |-> rdata_q == '0); // R10

  AST_READY_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> !rdy_q); // R2

  AST_BLANK_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (fire_i && sel_i == SEL_SECRET && consumed_i[sec_idx_i]) |=> rdata_q == '0); // R5

endmodule

// File: rtl/ros_secret_store.sv
`timescale 1ns/1ps
module ros_secret_store
  import ros_pkg::*;
#(
  parameter int                      DATA_W   = 32,
  parameter int                      WORDS    = 8,
  parameter int                      ADDR_W   = 8,
  parameter int                      ID_BASE  = 0,
  parameter int                      SEC_BASE = 16,
  parameter logic [DATA_W-1:0]       NAME0    = 32'h7365_6b72,
  parameter logic [DATA_W-1:0]       NAME1    = 32'h6f6e_6365,
  parameter logic [DATA_W-1:0]       VERSION  = 32'h0000_0001,
  parameter logic [DATA_W*WORDS-1:0] SECRET   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              app_mode_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdy_o
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  ros_sel_e         sel;
  logic [1:0]       id_idx;
  logic [IDX_W-1:0] sec_idx;
  logic [WORDS-1:0] consumed;
  logic             fire;
  logic             burn;
  logic             write_only;

  assign fire       = cs_i && rd_i;
  assign burn       = fire && !app_mode_i && (sel == SEL_SECRET);
  assign write_only = cs_i && wr_i && !rd_i;

  ros_addr_decode #(
    .ADDR_W   (ADDR_W),
    .WORDS    (WORDS),
    .ID_BASE  (ID_BASE),
    .SEC_BASE (SEC_BASE)
  ) i_decode (
    .addr_i    (addr_i),
    .sel_o     (sel),
    .id_idx_o  (id_idx),
    .sec_idx_o (sec_idx)
  );

  ros_fuse_bank #(
    .WORDS (WORDS)
  ) i_fuses (
    .clk        (clk),
    .rst        (rst),
    .burn_i     (burn),
    .burn_idx_i (sec_idx),
    .app_mode_i (app_mode_i),
    .consumed_o (consumed)
  );

  ros_read_port #(
    .DATA_W  (DATA_W),
    .WORDS   (WORDS),
    .NAME0   (NAME0),
    .NAME1   (NAME1),
    .VERSION (VERSION),
    .SECRET  (SECRET)
  ) i_port (
    .clk        (clk),
    .rst        (rst),
    .fire_i     (fire),
    .app_mode_i (app_mode_i),
    .sel_i      (sel),
    .id_idx_i   (id_idx),
    .sec_idx_i  (sec_idx),
    .consumed_i (consumed),
    .rdata_o    (rdata_o),
    .rdy_o      (rdy_o)
  );

  AST_READY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (cs_i && rd_i) |=> rdy_o); // R2

  AST_APP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cs_i && rd_i && app_mode_i) |=> rdata_o == '0); // R7

  AST_WRITE_NO_READY: assert property (@(posedge clk) disable iff (rst)
    write_only |=> !rdy_o); // R8

  AST_WRITE_NO_BURN: assert property (@(posedge clk) disable iff (rst)
    write_only |=> consumed == $past(consumed)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!rdy_o && rdata_o == '0)); // R1

endmodule

// File: tb/test_ros_secret_store.sv
`timescale 1ns/1ps
module test_ros_secret_store;

  localparam int DATA_W = 32;
  localparam int WORDS  = 8;
  localparam int ADDR_W = 8;
  localparam int SBASE  = 16;
  localparam logic [31:0] N0  = 32'h7365_6b72;
  localparam logic [31:0] N1  = 32'h6f6e_6365;
  localparam logic [31:0] VER = 32'h0000_0001;
  localparam logic [255:0] SEC =
    256'hA7A7_0707_B6B6_0606_C5C5_0505_D4D4_0404_E3E3_0303_F2F2_0202_1111_0101_9090_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs = 1'b0, rd = 1'b0, wr = 1'b0, app = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] rdata;
  logic              rdy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [WORDS-1:0] used_m = '0;

  always #5 clk = ~clk;

  ros_secret_store #(
    .DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W), .ID_BASE(0), .SEC_BASE(SBASE),
    .NAME0(N0), .NAME1(N1), .VERSION(VER), .SECRET(SEC)
  ) i_ros_secret_store (
    .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .app_mode_i(app), .rdata_o(rdata), .rdy_o(rdy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read value from the requirements and the bench's own marks
  function automatic logic [31:0] expect_word(input logic [7:0] a, input logic m);
    int off;
    if (m) return '0;                                   // R7
    if (a == 8'h00) return N0;                          // R3
    if (a == 8'h01) return N1;
    if (a == 8'h02) return VER;
    off = int'(a) - SBASE;
    if (off >= 0 && off < WORDS)
      return used_m[off] ? '0 : SEC[32*off +: 32];      // R4 R5
    return '0;                                          // R9
  endfunction

  function automatic void model_read(input logic [7:0] a, input logic m);
    int off;
    off = int'(a) - SBASE;
    if (!m && off >= 0 && off < WORDS) used_m[off] = 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cs = 0; rd = 0; wr = 0;
    @(negedge clk);
    @(posedge clk); #1;
    check("R1 rdy in reset", {31'd0, rdy}, 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    used_m = '0;
    @(posedge clk); #1;
    check("R1 rdy after reset", {31'd0, rdy}, 32'd0);
  endtask

  task automatic do_read(input logic [7:0] a, input logic m, input string req);
    logic [31:0] e;
    e = expect_word(a, m);
    @(negedge clk);
    cs = 1; rd = 1; wr = 0; addr = a; app = m;
    @(posedge clk); #1;
    check({req, " R2 ready"}, {31'd0, rdy}, 32'd1);
    check(req, rdata, e);
    model_read(a, m);
    @(negedge clk);
    cs = 0; rd = 0;
    @(posedge clk); #1;
    check("R2 ready drops", {31'd0, rdy}, 32'd0);
    check("R10 idle data", rdata, 32'd0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic m);
    @(negedge clk);
    cs = 1; rd = 0; wr = 1; addr = a; app = m;
    @(posedge clk); #1;
    check("R8 no ready on write", {31'd0, rdy}, 32'd0);
    check("R10 data on write", rdata, 32'd0);
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // Directed cases
    do_read(8'h00, 0, "R3 name0");
    do_read(8'h01, 0, "R3 name1");
    do_read(8'h02, 0, "R3 version");
    do_read(8'h03, 0, "R9 unmapped");
    do_read(8'hFF, 0, "R9 top address");
    do_read(8'h12, 1, "R7 app hides secret");
    do_read(8'h00, 1, "R7 app hides name");
    do_read(8'h12, 0, "R7 first fw read after app");
    do_read(8'h12, 0, "R5 second read blank");
    do_write(8'h13, 0);
    do_read(8'h13, 0, "R8 write did not consume");
    for (int k = 0; k < WORDS; k++) do_read(8'(SBASE + k), 0, "R4 secret sweep");
    do_read(8'h17, 0, "R5 last word blank");
    do_reset();
    do_read(8'h12, 0, "R6 word back after reset");
    do_read(8'h10, 0, "R6 first word back after reset");
    // Constrained random phase
    void'($urandom(32'd4242));
    for (int n = 0; n < 1500; n++) begin
      int          op;
      logic [7:0]  a;
      logic        m;
      op = int'($urandom % 100);
      m  = (($urandom % 5) == 0);
      case ($urandom % 4)
        0, 1:    a = 8'(SBASE + int'($urandom % WORDS));
        2:       a = 8'($urandom % 3);
        default: a = 8'($urandom);
      endcase
      if (op < 70)      do_read(a, m, "R4 R5 R7 random read");
      else if (op < 85) do_write(a, m);
      else if (op < 97) begin
        @(negedge clk); app = m; cs = 0;
        @(posedge clk); #1;
        check("R2 idle no ready", {31'd0, rdy}, 32'd0);
      end else          do_reset();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule